// File: doc/BRIEF.md
# Dual-Channel Sample Playback Engine

This block is the digital core of a two-channel arbitrary waveform source. A host loads one table of 8-bit DAC codes per channel and a few control registers. All of them sit in one byte-wide data space with a single write strobe and a combinational read port. Each channel then walks its table in a loop and presents one code per sample period on an 8-bit DAC output. The sample period comes from that channel's own 32-bit divisor.

Two further register types need no sequencing. A per-channel 8-bit filter-select register and a shared 8-bit attenuation register are passed straight to switch-control pins. The analog network that follows the DAC is outside this block. Reset leaves both outputs at mid-scale (code 128) with the smallest filter selected and no attenuation.

Each channel runs a two-state sequencer. `SEQ_RESTART` clears the sample index and the rate counter. Its only transition is to `SEQ_RUN` on the next clock. `SEQ_RUN` counts clocks and advances the index on each sample tick, wrapping after the last sample. It moves back to `SEQ_RESTART` whenever the host writes any byte of that channel's divisor or length. Reset also places the sequencer in `SEQ_RESTART`.

Top module: `dual_wave_player`

## Requirements
- R1: After reset both DAC outputs are 128, both filter outputs are 0x01, both attenuation outputs are 0, every sample location reads 128, and every divisor, length and attenuation byte reads 0x00.
- R2: Channel 1 samples live at 0x0000 plus offset and channel 2 samples at 0x4000 plus offset, one byte per address, for offsets below the table depth (256 by default). Every other address, including offsets at or above the depth inside 0x0000–0x1FFF and 0x4000–0x5FFF, reads 0x00, and writes to it have no effect.
- R3: Channel 1's 32-bit divisor is at 0x8002–0x8005 and channel 2's at 0x8006–0x8009, the lowest address holding bits 31:24; all bytes read back as written.
- R4: Channel 1's 16-bit length is at 0x800A–0x800B and channel 2's at 0x800C–0x800D, the lower address holding bits 15:8. One loop plays length+1 samples.
- R5: With divisor D, a channel's sample index advances once every 2·(D+1) clocks, so one sample tick is one period of half the system clock divided by D+1.
- R6: The index runs 0, 1, …, length and then returns to 0; it never exceeds the length register and otherwise only steps by one.
- R7: A channel's DAC output is registered; it shows the sample at the current index one clock after the index takes that value. After a restart the DAC output shows sample 0 from the second clock after the configuring write.
- R8: A write to 0x8000 (channel 1) or 0x8001 (channel 2) appears bit for bit on that channel's filter outputs on the next clock.
- R9: A write to 0x800E appears on the next clock with bits 3:0 on channel 1's attenuation outputs and bits 7:4 on channel 2's.
- R10: Writing any divisor or length byte of a channel restarts that channel at sample 0 with a cleared rate counter. Writes to sample, filter or attenuation addresses leave the playback sequence undisturbed.
- R11: The two channels play independently; configuring one does not alter the timing or data of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the data space |
| bus_addr | input | 16 | Byte address in the data space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ch1_dac | output | 8 | Channel 1 DAC code |
| ch2_dac | output | 8 | Channel 2 DAC code |
| ch1_filt_sw | output | 8 | Channel 1 filter switch controls, 1 closes |
| ch2_filt_sw | output | 8 | Channel 2 filter switch controls, 1 closes |
| ch1_atten_sw | output | 4 | Channel 1 attenuator switch controls |
| ch2_atten_sw | output | 4 | Channel 2 attenuator switch controls |

## Verification
Some properties are checked on every cycle: the index stays within the length and moves only by one step or back to zero. A configuring write forces the index to zero two clocks later. Filter and attenuation writes reach their pins on the next clock. The bench scenarios are the only place the exact tick spacing for a given divisor is shown. They also show the big-endian byte order and the mapping of DAC codes to table contents. The last things they show are that non-configuring writes leave the sequence unbroken and that one channel keeps its phase while the other is reprogrammed.

// File: rtl/wave_player_pkg.sv
package wave_player_pkg;

    localparam int NUM_CH = 2;

    // window of one channel's sample table (offset field width)
    localparam int WIN_W = 13;

    localparam logic [15:0] A_FILT_BASE = 16'h8000;
    localparam logic [15:0] A_DIV_BASE  = 16'h8002;
    localparam logic [15:0] A_LEN_BASE  = 16'h800A;
    localparam logic [15:0] A_ATTEN     = 16'h800E;

    localparam logic [7:0] DAC_MID      = 8'd128;
    localparam logic [7:0] FILT_DEFAULT = 8'h01;

    typedef enum logic [0:0] {
        SEQ_RESTART = 1'b0,
        SEQ_RUN     = 1'b1
    } seq_state_e;

endpackage

// File: rtl/wp_sample_mem.sv
module wp_sample_mem
    import wave_player_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] play_addr,
    output logic [7:0]    play_data,
    input  logic [AW-1:0] host_addr,
    output logic [7:0]    host_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= DAC_MID;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign play_data = mem_q[play_addr];
    assign host_data = mem_q[host_addr];

endmodule

// File: rtl/wp_chan_seq.sv
module wp_chan_seq
    import wave_player_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DIV_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    input  logic [LEN_W-1:0] length,
    input  logic [7:0]       samp_data,
    output logic [AW-1:0]    samp_addr,
    output logic [LEN_W-1:0] index,
    output logic [7:0]       dac
);

    // one tick per 2*(divisor+1) clocks: counter limit is 2*divisor+1
    localparam int CNT_W = DIV_W + 1;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [LEN_W-1:0] idx_q;
    logic [7:0]       dac_q;
    logic             tick;

    assign limit = {divisor, 1'b1};
    assign tick  = (state_q == SEQ_RUN) && (cnt_q == limit);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RESTART: state_d = SEQ_RUN;
            SEQ_RUN:     state_d = SEQ_RUN;
            default:     state_d = SEQ_RESTART;
        endcase
        if (restart) begin
            state_d = SEQ_RESTART;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RESTART;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and index per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_RESTART: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                SEQ_RUN: begin
                    if (tick) begin
                        cnt_q <= '0;
                        if (idx_q >= length) begin
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
            endcase
        end
    end

    // registered DAC code, one clock behind the index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q <= DAC_MID;
        end else begin
            dac_q <= samp_data;
        end
    end

    assign samp_addr = idx_q[AW-1:0];
    assign index     = idx_q;
    assign dac       = dac_q;

endmodule

// File: rtl/wp_ctrl_regs.sv
module wp_ctrl_regs
    import wave_player_pkg::*;
#(
    parameter int DIV_W = 32,
    parameter int LEN_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [15:0]                   addr,
    input  logic [7:0]                    wdata,
    output logic [NUM_CH-1:0][7:0]        filt,
    output logic [NUM_CH-1:0][DIV_W-1:0]  div,
    output logic [NUM_CH-1:0][LEN_W-1:0]  len,
    output logic [7:0]                    atten,
    output logic [NUM_CH-1:0]             cfg_hit,
    output logic [7:0]                    rd_data,
    output logic                          rd_hit
);

    localparam int DIV_B = DIV_W / 8;
    localparam int LEN_B = LEN_W / 8;

    logic [NUM_CH-1:0][7:0]       filt_q;
    logic [NUM_CH-1:0][DIV_W-1:0] div_q;
    logic [NUM_CH-1:0][LEN_W-1:0] len_q;
    logic [7:0]                   atten_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                filt_q[c] <= FILT_DEFAULT;
                div_q[c]  <= '0;
                len_q[c]  <= '0;
            end
            atten_q <= '0;
        end else if (we) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == A_FILT_BASE + 16'(c)) begin
                    filt_q[c] <= wdata;
                end
                for (int b = 0; b < DIV_B; b++) begin
                    if (addr == A_DIV_BASE + 16'(DIV_B * c + b)) begin
                        div_q[c][8*(DIV_B-1-b) +: 8] <= wdata;
                    end
                end
                for (int b = 0; b < LEN_B; b++) begin
                    if (addr == A_LEN_BASE + 16'(LEN_B * c + b)) begin
                        len_q[c][8*(LEN_B-1-b) +: 8] <= wdata;
                    end
                end
            end
            if (addr == A_ATTEN) begin
                atten_q <= wdata;
            end
        end
    end

    // configuring-write detect per channel
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg_hit[c] = 1'b0;
            for (int b = 0; b < DIV_B; b++) begin
                if (we && addr == A_DIV_BASE + 16'(DIV_B * c + b)) begin
                    cfg_hit[c] = 1'b1;
                end
            end
            for (int b = 0; b < LEN_B; b++) begin
                if (we && addr == A_LEN_BASE + 16'(LEN_B * c + b)) begin
                    cfg_hit[c] = 1'b1;
                end
            end
        end
    end

    // read decode
    always_comb begin
        rd_data = '0;
        rd_hit  = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == A_FILT_BASE + 16'(c)) begin
                rd_data = filt_q[c];
                rd_hit  = 1'b1;
            end
            for (int b = 0; b < DIV_B; b++) begin
                if (addr == A_DIV_BASE + 16'(DIV_B * c + b)) begin
                    rd_data = div_q[c][8*(DIV_B-1-b) +: 8];
                    rd_hit  = 1'b1;
                end
            end
            for (int b = 0; b < LEN_B; b++) begin
                if (addr == A_LEN_BASE + 16'(LEN_B * c + b)) begin
                    rd_data = len_q[c][8*(LEN_B-1-b) +: 8];
                    rd_hit  = 1'b1;
                end
            end
        end
        if (addr == A_ATTEN) begin
            rd_data = atten_q;
            rd_hit  = 1'b1;
        end
    end

    assign filt  = filt_q;
    assign div   = div_q;
    assign len   = len_q;
    assign atten = atten_q;

endmodule

// File: rtl/dual_wave_player.sv
module dual_wave_player
    import wave_player_pkg::*;
#(
    parameter int SAMPLE_AW = 8,
    parameter int DIV_W     = 32,
    parameter int LEN_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [7:0]  ch1_dac,
    output logic [7:0]  ch2_dac,
    output logic [7:0]  ch1_filt_sw,
    output logic [7:0]  ch2_filt_sw,
    output logic [3:0]  ch1_atten_sw,
    output logic [3:0]  ch2_atten_sw
);

    localparam int DEPTH = 1 << SAMPLE_AW;

    logic [NUM_CH-1:0][7:0]       filt_val;
    logic [NUM_CH-1:0][DIV_W-1:0] div_val;
    logic [NUM_CH-1:0][LEN_W-1:0] len_val;
    logic [7:0]                   atten_val;
    logic [NUM_CH-1:0]            cfg_hit;
    logic [7:0]                   reg_rdata;
    logic                         reg_hit;

    logic [NUM_CH-1:0]            samp_sel;
    logic [NUM_CH-1:0][7:0]       samp_rdata;
    logic [NUM_CH-1:0][7:0]       dac_val;
    logic [NUM_CH-1:0][LEN_W-1:0] seq_idx;
    logic [15:0]                  win_off;

    assign win_off = {{(16-WIN_W){1'b0}}, bus_addr[WIN_W-1:0]};

    wp_ctrl_regs #(
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .filt    (filt_val),
        .div     (div_val),
        .len     (len_val),
        .atten   (atten_val),
        .cfg_hit (cfg_hit),
        .rd_data (reg_rdata),
        .rd_hit  (reg_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SAMPLE_AW-1:0] play_addr;
        logic [7:0]           play_data;

        // window code: channel c at bus_addr[15:13] == 2*c
        assign samp_sel[c] = (bus_addr[15:WIN_W] == 3'(2 * c)) &&
                             (win_off < 16'(DEPTH));

        wp_sample_mem #(
            .AW (SAMPLE_AW)
        ) u_mem (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_we && samp_sel[c]),
            .wr_addr   (bus_addr[SAMPLE_AW-1:0]),
            .wr_data   (bus_wdata),
            .play_addr (play_addr),
            .play_data (play_data),
            .host_addr (bus_addr[SAMPLE_AW-1:0]),
            .host_data (samp_rdata[c])
        );

        wp_chan_seq #(
            .AW    (SAMPLE_AW),
            .DIV_W (DIV_W),
            .LEN_W (LEN_W)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (cfg_hit[c]),
            .divisor   (div_val[c]),
            .length    (len_val[c]),
            .samp_data (play_data),
            .samp_addr (play_addr),
            .index     (seq_idx[c]),
            .dac       (dac_val[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (reg_hit) begin
            bus_rdata = reg_rdata;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (samp_sel[c]) begin
                bus_rdata = samp_rdata[c];
            end
        end
    end

    assign ch1_dac      = dac_val[0];
    assign ch2_dac      = dac_val[1];
    assign ch1_filt_sw  = filt_val[0];
    assign ch2_filt_sw  = filt_val[1];
    assign ch1_atten_sw = atten_val[3:0];
    assign ch2_atten_sw = atten_val[7:4];

endmodule

// File: rtl/wp_checker.sv
module wp_checker
    import wave_player_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_we,
    input logic [15:0]                   bus_addr,
    input logic [7:0]                    bus_wdata,
    input logic [7:0]                    ch1_filt_sw,
    input logic [7:0]                    ch2_filt_sw,
    input logic [3:0]                    ch1_atten_sw,
    input logic [3:0]                    ch2_atten_sw,
    input logic [NUM_CH-1:0][LEN_W-1:0]  seq_idx,
    input logic [NUM_CH-1:0][LEN_W-1:0]  len_val,
    input logic [NUM_CH-1:0]             cfg_hit
);

    a_r8_filt1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FILT_BASE) |=> (ch1_filt_sw == $past(bus_wdata)));

    a_r8_filt2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FILT_BASE + 16'd1) |=> (ch2_filt_sw == $past(bus_wdata)));

    a_r9_atten_split: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ATTEN) |=> ({ch2_atten_sw, ch1_atten_sw} == $past(bus_wdata)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r6_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_hit[c] |=> (seq_idx[c] <= len_val[c]));

        a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(seq_idx[c]) |-> (seq_idx[c] == '0 || seq_idx[c] == $past(seq_idx[c]) + 1'b1));

        a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_hit[c] |=> ##1 (seq_idx[c] == '0));
    end

endmodule

bind dual_wave_player wp_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ch1_filt_sw  (ch1_filt_sw),
    .ch2_filt_sw  (ch2_filt_sw),
    .ch1_atten_sw (ch1_atten_sw),
    .ch2_atten_sw (ch2_atten_sw),
    .seq_idx      (seq_idx),
    .len_val      (len_val),
    .cfg_hit      (cfg_hit)
);

// File: tb/dual_wave_player_tb.sv
module dual_wave_player_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  ch1_dac, ch2_dac, ch1_filt_sw, ch2_filt_sw;
    logic [3:0]  ch1_atten_sw, ch2_atten_sw;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    dual_wave_player u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ch1_dac      (ch1_dac),
        .ch2_dac      (ch2_dac),
        .ch1_filt_sw  (ch1_filt_sw),
        .ch2_filt_sw  (ch2_filt_sw),
        .ch1_atten_sw (ch1_atten_sw),
        .ch2_atten_sw (ch2_atten_sw)
    );

    // scenario table: channel, divisor, length register, cycles observed
    localparam int VEC_N = 7;
    localparam int V_CH  [VEC_N] = '{0, 0, 1, 1, 0, 1, 0};
    localparam int V_DIV [VEC_N] = '{0, 2, 0, 1, 5, 256, 0};
    localparam int V_LEN [VEC_N] = '{3, 7, 0, 15, 1, 1, 15};
    localparam int V_OBS [VEC_N] = '{40, 120, 20, 200, 60, 1100, 80};

    function automatic logic [7:0] samp_val(input int ch, input int i);
        return 8'((ch * 91 + i * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] exp_dac(input int ch, input int dv, input int ln, input int k);
        int p;
        p = 2 * (dv + 1);
        return samp_val(ch, ((k - 2) / p) % (ln + 1));
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // called at a negedge; returns at the next negedge (one clock consumed)
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [15:0] a, input logic [7:0] expv, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == expv, req, bus_rdata, expv);
    endtask

    task automatic config_ch(input int ch, input int dv, input int ln);
        wr(16'h800A + 16'(2 * ch), 8'(ln >> 8));
        wr(16'h800B + 16'(2 * ch), 8'(ln));
        for (int b = 0; b < 4; b++) begin
            wr(16'h8002 + 16'(4 * ch + b), 8'(dv >> (8 * (3 - b))));
        end
    endtask

    // k counts clocks since the last configuring write; checks from k>=2
    task automatic observe(input int ch, input int dv, input int ln, inout int k,
                           input int n, input string req);
        int bad;
        logic [7:0] got, want, bgot, bwant;
        bad = 0; bgot = '0; bwant = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k++;
            if (k >= 2) begin
                got  = (ch == 0) ? ch1_dac : ch2_dac;
                want = exp_dac(ch, dv, ln, k);
                if (got != want && bad == 0) begin
                    bgot = got; bwant = want;
                end
                if (got != want) bad++;
            end
        end
        check(bad == 0, req, bgot, bwant);
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int k, k0, k1, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ch1_dac == 8'd128, "R1 ch1_dac", ch1_dac, 128);
        check(ch2_dac == 8'd128, "R1 ch2_dac", ch2_dac, 128);
        check(ch1_filt_sw == 8'h01 && ch2_filt_sw == 8'h01, "R1 filt", {ch2_filt_sw, ch1_filt_sw}, 16'h0101);
        check(ch1_atten_sw == 4'h0 && ch2_atten_sw == 4'h0, "R1 atten", {ch2_atten_sw, ch1_atten_sw}, 0);
        rd_check(16'h0005, 8'd128, "R1 sample ch1");
        rd_check(16'h40FF, 8'd128, "R1 sample ch2");
        rd_check(16'h8002, 8'h00, "R1 divisor");
        rd_check(16'h800D, 8'h00, "R1 length");
        rd_check(16'h800E, 8'h00, "R1 atten reg");

        // R2 sample tables
        @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < 16; i++) begin
                wr(16'(ch * 16'h4000 + i), samp_val(ch, i));
            end
        end
        rd_check(16'h0003, samp_val(0, 3), "R2 ch1 readback");
        rd_check(16'h400E, samp_val(1, 14), "R2 ch2 readback");
        @(negedge clk);
        wr(16'h0100, 8'hA5);
        wr(16'h2000, 8'h5A);
        wr(16'h8010, 8'h33);
        rd_check(16'h0100, 8'h00, "R2 beyond depth");
        rd_check(16'h0000, samp_val(0, 0), "R2 beyond depth no alias");
        rd_check(16'h2000, 8'h00, "R2 unmapped window");
        rd_check(16'h8010, 8'h00, "R2 unmapped register");

        // R3 big-endian divisor
        @(negedge clk);
        wr(16'h8006, 8'h12); wr(16'h8007, 8'h34); wr(16'h8008, 8'h56); wr(16'h8009, 8'h78);
        rd_check(16'h8006, 8'h12, "R3 div msb");
        rd_check(16'h8009, 8'h78, "R3 div lsb");
        // R4 length bytes
        @(negedge clk);
        wr(16'h800C, 8'h01); wr(16'h800D, 8'h23);
        rd_check(16'h800C, 8'h01, "R4 len high");
        rd_check(16'h800D, 8'h23, "R4 len low");

        // R8 filter, R9 attenuation
        @(negedge clk);
        wr(16'h8001, 8'h22);
        check(ch2_filt_sw == 8'h22, "R8 ch2 filt", ch2_filt_sw, 8'h22);
        check(ch1_filt_sw == 8'h01, "R8 ch1 filt untouched", ch1_filt_sw, 8'h01);
        wr(16'h8000, 8'h84);
        check(ch1_filt_sw == 8'h84, "R8 ch1 filt", ch1_filt_sw, 8'h84);
        wr(16'h800E, 8'h5A);
        check(ch1_atten_sw == 4'hA, "R9 ch1 atten", ch1_atten_sw, 4'hA);
        check(ch2_atten_sw == 4'h5, "R9 ch2 atten", ch2_atten_sw, 4'h5);

        // table of playback scenarios: R4 R5 R6 R7
        for (int v = 0; v < VEC_N; v++) begin
            config_ch(V_CH[v], V_DIV[v], V_LEN[v]);
            k = 0;
            observe(V_CH[v], V_DIV[v], V_LEN[v], k, V_OBS[v], "R5 R6 R7 playback");
        end

        // R10 rewrite of a length byte restarts at sample 0
        config_ch(0, 1, 3);
        k = 0;
        observe(0, 1, 3, k, 13, "R10 before restart");
        wr(16'h800B, 8'd3);
        k = 0;
        observe(0, 1, 3, k, 30, "R10 restart from sample 0");

        // R10 filter, attenuation and sample writes do not restart
        wr(16'h8000, 8'h11); k++;
        wr(16'h800E, 8'h00); k++;
        wr(16'h0020, 8'h77); k++;
        observe(0, 1, 3, k, 30, "R10 no restart on other writes");

        // R11 independent channels
        config_ch(0, 0, 7);
        k0 = 0;
        config_ch(1, 2, 5);
        k0 += 6;
        k1 = 0;
        bad = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            k0++; k1++;
            if (ch1_dac != exp_dac(0, 0, 7, k0)) bad++;
            if (k1 >= 2 && ch2_dac != exp_dac(1, 2, 5, k1)) bad++;
        end
        check(bad == 0, "R11 independent channels", bad, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule